// File: doc/BRIEF.md
# Flash Busy and Protection Controller

This block tracks the operating state of a flash memory device. There are four kinds of state: power-up recovery, idle, and busy with a read, a program or an erase. While an operation runs, the block asserts an output enable. That enable pulls a shared, active-low ready/busy wire to ground. Outside a busy period the driver is released, so several devices can share one wire with a single pull-up. The wire then reads low whenever any of them is busy.

An operation request is taken only in idle, and only with chip enable low. Program and erase requests are refused while write protect is low. Read requests are not affected by write protect. After reset, and after any loss of power-good, commands are held off for a recovery period. The period is a parameterised number of clock cycles, 250 cycles by default (1 µs at 250 MHz). Losing power-good cancels any operation in progress.

Chip enable going high during a busy period has a different effect for each operation:
- During a program or erase, it is ignored.
- During a read, it aborts the operation and returns the block to idle, unless the `CE_DONT_CARE` parameter is set. With that parameter set, the read continues.

Top module: `flash_busy_ctrl`

## Requirements
- R1: While reset is asserted, the block is in recovery, with `cmd_ready`=0, `busy_oe`=0, `req_accept`=0 and `req_reject`=0.
- R2: With `pwr_good` high, `cmd_ready` rises at the (RECOVERY_CYCLES+1)-th rising edge after reset is released. Requests made before then are neither accepted nor rejected, and start no busy period.
- R3: A read request (`req_op`=2'b00) made in idle with `ce_n`=0 sets `req_accept` in the same cycle, for either level of `wp_n`. From the next edge, `busy_oe`=1 and `cur_op`=2'b00.
- R4: A program request (2'b01) or an erase request (2'b10) made in idle with `ce_n`=0 and `wp_n`=1 is accepted. From the next edge, `busy_oe`=1 and `cur_op` holds the request code.
- R5: A program or erase request made with `wp_n`=0 sets `req_reject`, keeps `req_accept` at 0, and leaves `busy_oe` at 0 after the next edge.
- R6: `op_done` high at an edge during a busy period returns the block to idle at that edge, with `busy_oe`=0 and `cmd_ready`=1.
- R7: During a program or erase, `ce_n`=1 has no effect: `busy_oe` stays 1 and `cur_op` is unchanged.
- R8: With `CE_DONT_CARE`=0, `ce_n`=1 during a read raises `read_abort` in that cycle. From the next edge the block is idle, with `busy_oe`=0.
- R9: With `CE_DONT_CARE`=1, `ce_n`=1 during a read neither aborts it nor ends the busy period. `read_abort` stays 0.
- R10: `pwr_good` low at an edge moves the block to recovery at that edge, with `busy_oe`=0 and `cmd_ready`=0. `cmd_ready` rises again at the (RECOVERY_CYCLES+1)-th edge after `pwr_good` returns.
- R11: A request made while busy is ignored: `req_accept` and `req_reject` stay 0, and `cur_op` keeps its value.
- R12: A request made with `ce_n`=1 is ignored: `req_accept` and `req_reject` stay 0, and no busy period starts.
- R13: `busy_oe` is 1 exactly while a read, program or erase is in progress. Because the enable only ever pulls the wire low, several instances can share one ready/busy wire, and that wire reads low if any one of them is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good indication; low forces recovery |
| ce_n | input | 1 | Active-low chip enable |
| wp_n | input | 1 | Active-low write protect |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | Request code: 00 read, 01 program, 10 erase |
| op_done | input | 1 | Completion signal from the array model |
| busy_oe | output | 1 | Open-drain enable; 1 pulls ready/busy low |
| cmd_ready | output | 1 | Idle and able to take a request |
| req_accept | output | 1 | Current request is taken (combinational) |
| req_reject | output | 1 | Current request is refused by write protect (combinational) |
| read_abort | output | 1 | Chip enable is ending the current read (combinational) |
| cur_op | output | 2 | Code of the operation in progress |

## Verification
`req_accept`, `req_reject` and `read_abort` are combinational, so the bench samples them in the same cycle as the stimulus, half a clock after the inputs are driven. `busy_oe`, `cmd_ready` and `cur_op` come from the state register, so they are sampled one edge after the request, completion, chip-enable change or loss of power-good that moves them. Recovery is measured by counting rising edges from the release of reset, or from the return of power-good, until `cmd_ready` is seen. The count must be exactly RECOVERY_CYCLES+1. Two instances, one for each chip-enable option, share the stimulus. The wire they share is modelled as the NOR of their enables, which shows the difference between the two options during a read.

// File: rtl/flash_busy_pkg.sv
package flash_busy_pkg;

   typedef enum logic [2:0] {
      ST_RECOVER = 3'd0,
      ST_IDLE    = 3'd1,
      ST_READ    = 3'd2,
      ST_PROG    = 3'd3,
      ST_ERASE   = 3'd4
   } fbc_state_e;

   localparam logic [1:0] OP_READ  = 2'b00;
   localparam logic [1:0] OP_PROG  = 2'b01;
   localparam logic [1:0] OP_ERASE = 2'b10;

   function automatic logic is_busy(input fbc_state_e s);
      return (s == ST_READ) || (s == ST_PROG) || (s == ST_ERASE);
   endfunction

endpackage

// File: rtl/fbc_recovery_timer.sv
module fbc_recovery_timer #(
   parameter int RECOVERY_CYCLES = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   output logic expired
);
   localparam int CW = $clog2(RECOVERY_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(RECOVERY_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!pwr_good)
         cnt_q <= '0;
      else if (cnt_q != LIMIT)
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == LIMIT);

   // R10
   timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> !expired);

endmodule

// File: rtl/fbc_req_gate.sv
module fbc_req_gate
   import flash_busy_pkg::*;
(
   input  logic       idle,
   input  logic       req_valid,
   input  logic [1:0] req_op,
   input  logic       ce_n,
   input  logic       wp_n,
   output logic       accept,
   output logic       reject
);
   logic known_op, needs_wp, taken;

   assign known_op = (req_op == OP_READ) || (req_op == OP_PROG) || (req_op == OP_ERASE);
   assign needs_wp = (req_op == OP_PROG) || (req_op == OP_ERASE);
   assign taken    = idle && req_valid && !ce_n && known_op;

   assign accept = taken && !(needs_wp && !wp_n);
   assign reject = taken && needs_wp && !wp_n;

   // R5
   always_comb begin
      wp_block_chk: assert (!(accept && needs_wp && !wp_n));
   end

endmodule

// File: rtl/fbc_state_fsm.sv
module fbc_state_fsm
   import flash_busy_pkg::*;
#(
   parameter bit CE_DONT_CARE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_good,
   input  logic       rec_expired,
   input  logic       accept,
   input  logic [1:0] req_op,
   input  logic       op_done,
   input  logic       ce_n,
   output fbc_state_e state,
   output logic [1:0] cur_op,
   output logic       read_abort
);
   fbc_state_e state_q, state_d;
   logic [1:0] op_q;
   logic       ce_abort;

   generate
      if (CE_DONT_CARE) begin : g_ce_dc
         assign ce_abort = 1'b0;
      end else begin : g_ce_strict
         assign ce_abort = ce_n;
      end
   endgenerate

   assign read_abort = pwr_good && (state_q == ST_READ) && !op_done && ce_abort;

   always_comb begin
      state_d = state_q;
      if (!pwr_good) begin
         state_d = ST_RECOVER;
      end else begin
         case (state_q)
            ST_RECOVER: if (rec_expired) state_d = ST_IDLE;
            ST_IDLE: begin
               if (accept) begin
                  case (req_op)
                     OP_PROG:  state_d = ST_PROG;
                     OP_ERASE: state_d = ST_ERASE;
                     default:  state_d = ST_READ;
                  endcase
               end
            end
            ST_READ:  if (op_done || ce_abort) state_d = ST_IDLE;
            ST_PROG,
            ST_ERASE: if (op_done) state_d = ST_IDLE;
            default:  state_d = ST_RECOVER;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RECOVER;
         op_q    <= OP_READ;
      end else begin
         state_q <= state_d;
         if (accept && state_q == ST_IDLE && pwr_good)
            op_q <= req_op;
      end
   end

   assign state  = state_q;
   assign cur_op = op_q;

   // R6
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_good && is_busy(state_q) && op_done) |=> (state_q == ST_IDLE));

   // R7
   pe_ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_good && (state_q == ST_PROG || state_q == ST_ERASE) && ce_n && !op_done)
      |=> $stable(state_q));

   // R10
   pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (state_q == ST_RECOVER));

   generate
      if (CE_DONT_CARE) begin : g_chk_dc
         // R9
         read_dc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_good && state_q == ST_READ && ce_n && !op_done) |=> (state_q == ST_READ));
      end else begin : g_chk_strict
         // R8
         read_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_good && state_q == ST_READ && ce_n) |=> (state_q == ST_IDLE));
      end
   endgenerate

endmodule

// File: rtl/flash_busy_ctrl.sv
module flash_busy_ctrl
   import flash_busy_pkg::*;
#(
   parameter int RECOVERY_CYCLES = 250,
   parameter bit CE_DONT_CARE    = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_good,
   input  logic       ce_n,
   input  logic       wp_n,
   input  logic       req_valid,
   input  logic [1:0] req_op,
   input  logic       op_done,
   output logic       busy_oe,
   output logic       cmd_ready,
   output logic       req_accept,
   output logic       req_reject,
   output logic       read_abort,
   output logic [1:0] cur_op
);
   generate
      if (RECOVERY_CYCLES < 1) begin : g_bad_recovery
         $error("RECOVERY_CYCLES must be at least 1");
      end
   endgenerate

   fbc_state_e state;
   logic       rec_expired;
   logic       idle;

   assign idle = pwr_good && (state == ST_IDLE);

   fbc_recovery_timer #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_good (pwr_good),
      .expired  (rec_expired)
   );

   fbc_req_gate u_gate (
      .idle      (idle),
      .req_valid (req_valid),
      .req_op    (req_op),
      .ce_n      (ce_n),
      .wp_n      (wp_n),
      .accept    (req_accept),
      .reject    (req_reject)
   );

   fbc_state_fsm #(.CE_DONT_CARE(CE_DONT_CARE)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwr_good    (pwr_good),
      .rec_expired (rec_expired),
      .accept      (req_accept),
      .req_op      (req_op),
      .op_done     (op_done),
      .ce_n        (ce_n),
      .state       (state),
      .cur_op      (cur_op),
      .read_abort  (read_abort)
   );

   assign busy_oe   = is_busy(state);
   assign cmd_ready = (state == ST_IDLE);

   // R11
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_oe |-> !(req_accept || req_reject));

   // R2
   recover_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RECOVER) |-> !(req_accept || req_reject));

   // R13
   never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_oe && cmd_ready));

endmodule

// File: tb/flash_busy_ctrl_test.sv
module flash_busy_ctrl_test;
   localparam int REC = 250;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b1;
   logic ce_n = 1'b1;
   logic wp_n = 1'b1;
   logic req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic op_done = 1'b0;

   logic a_oe, a_rdy, a_acc, a_rej, a_abt;
   logic b_oe, b_rdy, b_acc, b_rej, b_abt;
   logic [1:0] a_op, b_op;
   logic rb_line;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   flash_busy_ctrl #(.RECOVERY_CYCLES(REC), .CE_DONT_CARE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .wp_n(wp_n),
      .req_valid(req_valid), .req_op(req_op), .op_done(op_done),
      .busy_oe(a_oe), .cmd_ready(a_rdy), .req_accept(a_acc), .req_reject(a_rej),
      .read_abort(a_abt), .cur_op(a_op));

   flash_busy_ctrl #(.RECOVERY_CYCLES(REC), .CE_DONT_CARE(1'b1)) uut_dc (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .wp_n(wp_n),
      .req_valid(req_valid), .req_op(req_op), .op_done(op_done),
      .busy_oe(b_oe), .cmd_ready(b_rdy), .req_accept(b_acc), .req_reject(b_rej),
      .read_abort(b_abt), .cur_op(b_op));

   assign rb_line = !(a_oe || b_oe);

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic count_to_ready(input string tag);
      int n = 0;
      while (!a_rdy && n < 2000) begin
         step();
         n++;
      end
      check(n == REC + 1, tag, n, REC + 1);
   endtask

   task automatic issue(input logic [1:0] op);
      req_valid = 1'b1;
      req_op    = op;
      ce_n      = 1'b0;
   endtask

   task automatic finish_op();
      op_done = 1'b1;
      step();
      op_done = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(!a_rdy && !a_oe && !b_oe, "R1 reset outputs", {a_rdy, a_oe}, 0);
      issue(2'b00);
      #0;
      check(!a_acc && !a_rej, "R1 no accept in reset", a_acc, 0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      issue(2'b00);
      step();
      check(!a_acc && !a_oe, "R2 request during recovery ignored", a_oe, 0);
      req_valid = 1'b0;
      step();
      check(!a_oe, "R2 no busy from early request", a_oe, 0);
      begin
         int n = 2;
         while (!a_rdy && n < 2000) begin
            step();
            n++;
         end
         check(n == REC + 1, "R2 recovery length", n, REC + 1);
      end
   endtask

   task automatic t_read_wp();
      wp_n = 1'b0;
      issue(2'b00);
      #1;
      check(a_acc && !a_rej, "R3 read accepted with wp low", a_acc, 1);
      step();
      req_valid = 1'b0;
      check(a_oe && a_op == 2'b00, "R3 busy on read", a_oe, 1);
      check(!rb_line, "R13 shared line low while busy", rb_line, 0);
      finish_op();
      check(!a_oe && a_rdy, "R6 read done releases", a_oe, 0);
      check(rb_line, "R13 shared line released", rb_line, 1);
      wp_n = 1'b1;
   endtask

   task automatic t_prog_ce_busy();
      issue(2'b01);
      #1;
      check(a_acc, "R4 program accepted", a_acc, 1);
      step();
      req_valid = 1'b0;
      check(a_oe && a_op == 2'b01, "R4 program busy", a_op, 1);
      ce_n = 1'b1;
      for (int i = 0; i < 3; i++) step();
      check(a_oe && a_op == 2'b01, "R7 ce high ignored in program", a_oe, 1);
      ce_n = 1'b0;
      issue(2'b10);
      #1;
      check(!a_acc && !a_rej, "R11 request while busy ignored", a_acc, 0);
      step();
      req_valid = 1'b0;
      check(a_op == 2'b01 && a_oe, "R11 op unchanged", a_op, 1);
      finish_op();
      check(!a_oe && a_rdy, "R6 program done", a_oe, 0);
   endtask

   task automatic t_erase();
      wp_n = 1'b0;
      issue(2'b10);
      #1;
      check(a_rej && !a_acc, "R5 erase rejected by wp", a_rej, 1);
      step();
      check(!a_oe, "R5 no busy after reject", a_oe, 0);
      issue(2'b01);
      #1;
      check(a_rej && !a_acc, "R5 program rejected by wp", a_rej, 1);
      step();
      req_valid = 1'b0;
      check(!a_oe, "R5 no busy after program reject", a_oe, 0);
      wp_n = 1'b1;
      issue(2'b10);
      step();
      req_valid = 1'b0;
      check(a_oe && a_op == 2'b10, "R4 erase busy", a_op, 2);
      ce_n = 1'b1;
      step();
      check(a_oe, "R7 ce high ignored in erase", a_oe, 1);
      ce_n = 1'b0;
      finish_op();
   endtask

   task automatic t_ce_high_req();
      req_valid = 1'b1;
      req_op    = 2'b00;
      ce_n      = 1'b1;
      #1;
      check(!a_acc && !a_rej, "R12 request with ce high", a_acc, 0);
      step();
      req_valid = 1'b0;
      check(!a_oe && a_rdy, "R12 no busy", a_oe, 0);
      ce_n = 1'b0;
   endtask

   task automatic t_read_abort();
      issue(2'b00);
      step();
      req_valid = 1'b0;
      check(a_oe && b_oe, "R3 both busy on read", {a_oe, b_oe}, 3);
      ce_n = 1'b1;
      #1;
      check(a_abt, "R8 abort flagged", a_abt, 1);
      check(!b_abt, "R9 no abort with dont-care", b_abt, 0);
      step();
      check(!a_oe && a_rdy, "R8 read aborted to idle", a_oe, 0);
      check(b_oe, "R9 read continues with dont-care", b_oe, 1);
      check(!rb_line, "R13 shared line held by other device", rb_line, 0);
      ce_n = 1'b0;
      finish_op();
      check(!b_oe && rb_line, "R6 dont-care read done", b_oe, 0);
   endtask

   task automatic t_power_loss();
      issue(2'b01);
      step();
      req_valid = 1'b0;
      check(a_oe, "R4 program before power loss", a_oe, 1);
      pwr_good = 1'b0;
      step();
      check(!a_oe && !a_rdy, "R10 power loss cancels", a_oe, 0);
      pwr_good = 1'b1;
      count_to_ready("R10 recovery after power return");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_read_wp();
      t_prog_ce_busy();
      t_erase();
      t_ce_high_req();
      t_read_abort();
      t_power_loss();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule